// File: doc/BRIEF.md
# Three-Valued Gate Evaluation Unit

This unit evaluates primitive gates for a hardware gate-level simulation engine, using three logic values: 0, 1 and X. X stands for an unknown value that may be either 0 or 1. Every gate kind is described by two bits. One is its controlling value c. The other is its inversion i. AND is (c=0,i=0), OR is (1,0), NAND is (0,1) and NOR is (1,1).

A small register file holds per-gate state: the kind bits, a count of inputs at the controlling value, a count of inputs at X, and the last output produced. An initialise command loads a gate's kind and fills both counts by scanning up to NIN inputs at once. After that, update events each describe a single input change as an old value and a new value. The unit adjusts the two counts from that event alone, without rescanning the inputs. It returns the gate's new output and a flag that says whether the output changed. A stateless scan command evaluates an arbitrary gate directly from a full input vector.

Top module: `gate_eval3`

## Requirements
- R1: While reset is asserted and afterwards until a command is accepted, out_valid and out_changed are 0. Reset leaves every gate's stored output at X, so a first initialise that yields X reports out_changed = 0.
- R2: Values are 2-bit codes: 00 means 0, 01 means 1, and 10 means X. The code 11 on any input is read as X. The output never carries 11.
- R3: If any counted input equals the controlling value c, the output is c XOR i. The kind codes {i,c} are: AND = 00, OR = 01, NAND = 10, NOR = 11.
- R4: If no input is at c and at least one input is X, the output is X (10).
- R5: If every counted input holds the non-controlling value, the output is (NOT c) XOR i.
- R6: Op code 01 (initialise) stores cmd_ctrl and cmd_inv for gate cmd_gate and sets both of its counts from the inputs whose cmd_mask bit is 1. Input k occupies cmd_vals[2k+1:2k], and inputs with a mask bit of 0 have no effect.
- R7: Op code 00 (update) changes the stored counts of gate cmd_gate using ev_old and ev_new, judged against that gate's stored c. Moving away from c decrements the c count, moving to c increments it, and the X count follows in the same way. The output is then evaluated from the new counts.
- R8: For initialise and update, out_changed is 1 for exactly that one result cycle when the new output differs from the gate's stored output. The new output then becomes the stored output.
- R9: Op code 10 (scan) evaluates cmd_ctrl, cmd_inv, cmd_mask and cmd_vals directly. It always reports out_changed = 0 and does not alter any gate's state.
- R10: Op code 11 is ignored. It produces no out_valid and alters no gate state.
- R11: Each accepted command yields out_valid for exactly the following cycle, with out_val registered in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 update, 01 initialise, 10 scan, 11 none |
| cmd_gate | input | GW | Gate index for update and initialise |
| cmd_ctrl | input | 1 | Controlling value c for initialise and scan |
| cmd_inv | input | 1 | Inversion i for initialise and scan |
| cmd_mask | input | NIN | Which inputs take part in a scan |
| cmd_vals | input | 2*NIN | Input values, 2 bits each |
| ev_old | input | 2 | Previous value of the changed input (update) |
| ev_new | input | 2 | New value of the changed input (update) |
| out_valid | output | 1 | Result present |
| out_val | output | 2 | Evaluated gate output |
| out_changed | output | 1 | Output differs from the stored value |

## Verification
A wrong count inside the unit stays hidden until an event moves a gate across a boundary. For example, a c count that has drifted can keep the output pinned at c XOR i after the last controlling input has left. The bench therefore runs long chains of single-input updates against a model that tracks every input. Each result is compared in the cycle after its command, so a fault shows up on the first event whose outcome depends on it. State that a scan or an ignored op code might corrupt is exposed by an update whose old value equals its new value, which must report the model's output with no change flag.

// File: rtl/gate_eval3.sv
module gate_eval3 #(
  parameter int NGATES = 4,
  parameter int NIN    = 8,
  localparam int GW    = (NGATES > 1) ? $clog2(NGATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [GW-1:0]    cmd_gate,
  input  logic             cmd_ctrl,
  input  logic             cmd_inv,
  input  logic [NIN-1:0]   cmd_mask,
  input  logic [2*NIN-1:0] cmd_vals,
  input  logic [1:0]       ev_old,
  input  logic [1:0]       ev_new,
  output logic             out_valid,
  output logic [1:0]       out_val,
  output logic             out_changed
);
  localparam int CW = $clog2(NIN + 1);
  localparam logic [1:0] OP_UPD = 2'd0, OP_SCAN = 2'd2, OP_NONE = 2'd3;
  localparam logic [1:0] V_X = 2'b10;

  logic [CW-1:0] g_cc [NGATES];
  logic [CW-1:0] g_xc [NGATES];
  logic          g_c  [NGATES];
  logic          g_i  [NGATES];
  logic [1:0]    g_out[NGATES];

  logic [CW-1:0] sc_c, sc_x;
  always_comb begin
    sc_c = '0;
    sc_x = '0;
    for (int k = 0; k < NIN; k++) begin
      if (cmd_mask[k]) begin
        if (cmd_vals[2*k+1])                sc_x = sc_x + CW'(1);
        else if (cmd_vals[2*k] == cmd_ctrl) sc_c = sc_c + CW'(1);
      end
    end
  end

  logic take, upd, sel_c, sel_i, old_hit, new_hit;
  logic [CW-1:0] nx_c, nx_x;
  logic [1:0] res;

  assign take    = cmd_valid && (cmd_op != OP_NONE);
  assign upd     = (cmd_op == OP_UPD);
  assign sel_c   = upd ? g_c[cmd_gate] : cmd_ctrl;
  assign sel_i   = upd ? g_i[cmd_gate] : cmd_inv;
  assign old_hit = !ev_old[1] && (ev_old[0] == sel_c);
  assign new_hit = !ev_new[1] && (ev_new[0] == sel_c);
  assign nx_c = upd ? g_cc[cmd_gate] + CW'(new_hit) - CW'(old_hit) : sc_c;
  assign nx_x = upd ? g_xc[cmd_gate] + CW'(ev_new[1]) - CW'(ev_old[1]) : sc_x;
  assign res  = (nx_c != '0) ? {1'b0, sel_c ^ sel_i} :
                (nx_x != '0) ? V_X : {1'b0, ~(sel_c ^ sel_i)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_val     <= V_X;
      out_changed <= 1'b0;
      for (int g = 0; g < NGATES; g++) begin
        g_cc[g]  <= '0;
        g_xc[g]  <= '0;
        g_c[g]   <= 1'b0;
        g_i[g]   <= 1'b0;
        g_out[g] <= V_X;
      end
    end else begin
      out_valid   <= take;
      out_changed <= 1'b0;
      if (take) begin
        out_val <= res;
        if (cmd_op != OP_SCAN) begin
          out_changed     <= (res != g_out[cmd_gate]);
          g_cc[cmd_gate]  <= nx_c;
          g_xc[cmd_gate]  <= nx_x;
          g_c[cmd_gate]   <= sel_c;
          g_i[cmd_gate]   <= sel_i;
          g_out[cmd_gate] <= res;
        end
      end
    end
  end
endmodule

// File: rtl/gate_eval3_chk.sv
module gate_eval3_chk #(
  parameter int NIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             cmd_ctrl,
  input logic             cmd_inv,
  input logic [NIN-1:0]   cmd_mask,
  input logic [2*NIN-1:0] cmd_vals,
  input logic             out_valid,
  input logic [1:0]       out_val,
  input logic             out_changed
);
  logic [NIN-1:0] hit;
  for (genvar k = 0; k < NIN; k++) begin : g_hit
    assign hit[k] = cmd_mask[k] && !cmd_vals[2*k+1] && (cmd_vals[2*k] == cmd_ctrl);
  end

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'd3) |=> out_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op != 2'd3) |=> !out_valid);
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_val != 2'b11);
  p_changed_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_changed |-> out_valid);
  p_scan_nochange_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> !out_changed);
  p_ctrl_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2) && (|hit))
      |=> out_val == {1'b0, $past(cmd_ctrl ^ cmd_inv)});
endmodule

bind gate_eval3 gate_eval3_chk #(.NIN(NIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ctrl(cmd_ctrl), .cmd_inv(cmd_inv), .cmd_mask(cmd_mask),
  .cmd_vals(cmd_vals), .out_valid(out_valid), .out_val(out_val),
  .out_changed(out_changed)
);

// File: tb/gate_eval3_bench.sv
module gate_eval3_bench;
  localparam int NG = 4, NI = 8, GW = 2;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_ctrl = 1'b0, cmd_inv = 1'b0;
  logic [1:0] cmd_op = 2'd0, ev_old = 2'd0, ev_new = 2'd0;
  logic [GW-1:0] cmd_gate = '0;
  logic [NI-1:0] cmd_mask = '0;
  logic [2*NI-1:0] cmd_vals = '0;
  logic out_valid, out_changed;
  logic [1:0] out_val;

  always #2 clk = ~clk;

  gate_eval3 #(.NGATES(NG), .NIN(NI)) u_gate_eval3 (.*);

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [2*NI-1:0] m_vals [NG];
  logic [NI-1:0]   m_mask [NG];
  logic m_c [NG], m_i [NG];
  logic [1:0] m_out [NG];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [1:0] ref_eval(logic c, logic i, logic [NI-1:0] m, logic [2*NI-1:0] v);
    bit anyc = 0, anyx = 0;
    for (int k = 0; k < NI; k++)
      if (m[k]) begin
        if (v[2*k+1]) anyx = 1;
        else if (v[2*k] == c) anyc = 1;
      end
    if (anyc) return {1'b0, c ^ i};
    if (anyx) return 2'b10;
    return {1'b0, ~(c ^ i)};
  endfunction

  task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [GW-1:0] g, logic c, logic i,
                      logic [NI-1:0] m, logic [2*NI-1:0] v, logic [1:0] o, logic [1:0] n);
    @(negedge clk);
    cmd_op = op; cmd_gate = g; cmd_ctrl = c; cmd_inv = i;
    cmd_mask = m; cmd_vals = v; ev_old = o; ev_new = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic string rule_tag(logic [1:0] e, logic c, logic i);
    if (e == 2'b10) return "R4";
    return (e[0] == (c ^ i)) ? "R3" : "R5";
  endfunction

  task automatic do_init(int g, logic c, logic i, logic [NI-1:0] m, logic [2*NI-1:0] v, string tag);
    logic [1:0] e;
    e = ref_eval(c, i, m, v);
    send(2'd1, GW'(g), c, i, m, v, 2'd0, 2'd0);
    check({tag, " init value"}, out_val, e);
    check({tag, " init changed R8"}, {1'b0, out_changed}, {1'b0, e != m_out[g]});
    m_c[g] = c; m_i[g] = i; m_mask[g] = m; m_vals[g] = v; m_out[g] = e;
  endtask

  task automatic do_update(int g, int k, logic [1:0] nv, string tag);
    logic [1:0] ov, e;
    ov = m_vals[g][2*k+:2];
    m_vals[g][2*k+:2] = nv;
    e = ref_eval(m_c[g], m_i[g], m_mask[g], m_vals[g]);
    send(2'd0, GW'(g), 1'b0, 1'b0, '0, '0, ov, nv);
    check({tag, " R7 update value"}, out_val, e);
    check({tag, " R8 changed"}, {1'b0, out_changed}, {1'b0, e != m_out[g]});
    check({tag, " R11 valid"}, {1'b0, out_valid}, 2'b01);
    m_out[g] = e;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_out[g] = 2'b10; m_c[g] = 0; m_i[g] = 0; m_mask[g] = '0; m_vals[g] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {1'b0, out_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {1'b0, out_valid}, 2'b00);
    check("R1 changed after reset", {1'b0, out_changed}, 2'b00);

    // R1: stored output is X after reset, so an X result reports no change
    do_init(0, 1'b0, 1'b0, 8'h01, 16'h0002, "R1");

    // scan sweep: all kinds, 4 inputs, every 2-bit code including 11 (R2)
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 256; p++) begin
        logic [1:0] e;
        e = ref_eval(t[0], t[1], 8'h0F, {8'hFF, 8'(p)});
        send(2'd2, '0, t[0], t[1], 8'h0F, {8'hFF, 8'(p)}, 2'd0, 2'd0);
        check({rule_tag(e, t[0], t[1]), " R2 R9 scan value"}, out_val, e);
        check("R9 scan changed", {1'b0, out_changed}, 2'b00);
        check("R11 scan valid", {1'b0, out_valid}, 2'b01);
      end
    @(negedge clk);
    check("R11 valid drops when idle", {1'b0, out_valid}, 2'b00);

    // R6: masked-out inputs at the controlling value are ignored
    for (int g = 0; g < NG; g++) begin
      logic c, i;
      logic [2*NI-1:0] v;
      c = g[0]; i = g[1];
      for (int k = 0; k < NI; k++) v[2*k+:2] = (k < 4) ? {1'b0, ~c} : {1'b0, c};
      do_init(g, c, i, 8'h0F, v, "R6 R5");
    end

    // R9: a scan leaves gate state alone; a no-op update exposes it
    send(2'd2, 2'd1, 1'b0, 1'b0, 8'hFF, 16'h0000, 2'd0, 2'd0);
    do_update(1, 0, m_vals[1][1:0], "R9 after scan");

    // R10: op 11 is ignored
    send(2'd3, 2'd2, 1'b1, 1'b1, 8'hFF, 16'hAAAA, 2'd0, 2'd0);
    check("R10 no valid for op 11", {1'b0, out_valid}, 2'b00);
    do_update(2, 1, m_vals[2][3:2], "R10 state kept");

    // R7 R8: long chains of single-input updates across all gates
    for (int n = 0; n < 1500; n++) begin
      int g, k;
      seed = seed * 32'd1103515245 + 32'd12345;
      g = int'(seed[17:16]);
      k = int'(seed[21:20]);
      do_update(g, k, seed[25:24], "R7 chain");
    end

    // re-initialise with all inputs counted and keep updating (R6 R7)
    for (int g = 0; g < NG; g++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      do_init(g, seed[3], seed[4], 8'hFF, seed[31:16], "R6 full");
    end
    for (int n = 0; n < 1500; n++) begin
      int g, k;
      seed = seed * 32'd1103515245 + 32'd12345;
      g = int'(seed[17:16]);
      k = int'(seed[22:20]);
      do_update(g, k, seed[25:24], "R7 full chain");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule